// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a single-cycle-deselect synchronous burst SRAM with a small internal array. Each word holds four byte lanes of nine bits. On every rising clock edge the core samples three chip selects, two address strobes, a step input and the write controls. From these it decides whether the cycle is idle, starts a burst, steps the burst, or holds it. It then reads the word at the chosen address or writes the selected lanes of it.

Reads come out on `dout` with a tristate enable, `drv_en`, for the external data pins. A static mode input chooses the read latency. In flow-through mode the word appears right after the edge that sampled the address. In pipelined mode it passes through one more register. The two low address bits are stepped by a burst sequencer, which counts in linear or interleaved order. `out_en_n` is asynchronous and can switch the drivers off at any time. It can only switch them on when valid read data is present.

Top module: `sbsram_core`

## Requirements
- R1: The chip counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe-started cycle without full selection is idle: nothing is written and the drivers are off after it.
- R2: With `sel_a_n`=1 and `ctl_strb_n`=0, the cycle is idle. With `sel_a_n`=1, `host_strb_n` is ignored, so `host_strb_n`=0 with `ctl_strb_n`=1 acts as a step or hold cycle.
- R3: `host_strb_n`=0 with `sel_a_n`=0 and full selection starts a burst at `addr`. This cycle is a read whatever the write controls are.
- R4: `host_strb_n`=1 and `ctl_strb_n`=0 with full selection starts a burst at `addr`. It is a write when the write term is true and a read otherwise.
- R5: With both strobes high, `step_n`=0 moves to the next burst address and `step_n`=1 repeats the current one. Either cycle reads or writes according to the write term.
- R6: The upper address bits stay fixed for the whole burst. The two low bits for beat n (0..3, wrapping after the fourth beat) are (start+n) mod 4 when `seq_linear`=1 and start XOR n when `seq_linear`=0.
- R7: The write term is `wr_all_n`=0 or `wr_byte_n`=0. `wr_all_n`=0 writes all four lanes. Otherwise `wr_byte_n`=0 writes only the lanes i whose `lane_n[i]` is 0, where lane i is `din[9i+8:9i]`. When both inputs are high, the cycle is a read.
- R8: With `pipe_mode`=0, a read sampled at edge k shows its word on `dout` from just after edge k until edge k+1. With `pipe_mode`=1 it shows from just after edge k+1 until edge k+2.
- R9: A write cycle never drives the outputs: the output slot it occupies has `drv_en`=0. A read drives all four lanes regardless of `lane_n`.
- R10: `drv_en` is 1 exactly when valid read data is presented and `out_en_n`=0. A change of `out_en_n` takes effect without waiting for a clock edge.
- R11: In pipelined mode, the read before an idle cycle still presents its data for one cycle, and the drivers turn off one cycle later.
- R12: After reset `drv_en`=0 and `dout`=0. `dout` is 0 whenever no valid read data is presented.
- R13: Write data is taken at the same edge as its address. A read at a later edge returns the updated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | External word address |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| host_strb_n | input | 1 | Host address strobe, active low, read-only start |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Lane write qualifier, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| seq_linear | input | 1 | 1 selects linear burst order, 0 interleaved |
| pipe_mode | input | 1 | 1 selects pipelined reads, 0 flow-through |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| drv_en | output | 1 | Enable for the external data drivers |

## Verification
The assertions check four things on every clock. An idle cycle leaves the drivers off one edge later in flow-through mode and two edges later in pipelined mode. A write cycle never turns on the flow-through drivers. The burst sequencer keeps its low address bits on a hold and always changes them on a step. Other behaviour can only be seen in the bench's scenarios against its own memory model: the contents returned after lane-masked writes, the exact linear and interleaved order including the wrap, strobe priority under partial selection, and the one-cycle data latency difference between the modes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        CY_IDLE = 2'd0,
        CY_LOAD = 2'd1,
        CY_STEP = 2'd2,
        CY_HOLD = 2'd3
    } cyc_t;

    typedef struct packed {
        logic [1:0] base;
        logic [1:0] cnt;
    } seq_st_t;

    // Low address bits for beat n of a burst that started at base.
    function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       linear);
        return linear ? (base + n) : (base ^ n);
    endfunction

endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       adv,
    input  logic [1:0] load_lo,
    input  logic       linear,
    output logic [1:0] eff_lo
);

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            eff_lo      = load_lo;
            st_d.base   = load_lo;
            st_d.cnt    = 2'd0;
        end else if (adv) begin
            st_d.cnt    = st_q.cnt + 2'd1;
            eff_lo      = beat_lo(st_q.base, st_d.cnt, linear);
        end else begin
            eff_lo      = beat_lo(st_q.base, st_q.cnt, linear);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a hold repeats the previous low address bits
    a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !load && !adv && $stable(linear)) |-> (eff_lo == $past(eff_lo)));

    // R5/R6: a step always moves to a different beat
    a_r5_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !load && adv && $stable(linear)) |-> (eff_lo != $past(eff_lo)));

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] bit_mask;

    // R7: expand lane enables into a per-bit write mask
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bit_mask[i*LANE_W +: LANE_W] = {LANE_W{we[i]}};
    end

    always_ff @(posedge clk) begin
        if (|we) mem[waddr] <= (mem[waddr] & ~bit_mask) | (wdata & bit_mask);
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    host_strb_n,
    input  logic                    ctl_strb_n,
    input  logic                    step_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    seq_linear,
    input  logic                    pipe_mode,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    drv_en
);

    localparam int DW   = LANES * LANE_W;
    localparam int HI_W = ADDR_W - 2;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [ADDR_W-1:0] raddr;
        logic              rdv;
        logic              pv;
        logic [DW-1:0]     pdata;
    } core_st_t;

    core_st_t          st_d, st_q;
    cyc_t              kind;
    logic              cyc_wr;
    logic              sel_ok;
    logic              wr_term;
    logic [LANES-1:0]  lane_mask;
    logic [LANES-1:0]  we;
    logic [1:0]        eff_lo;
    logic [ADDR_W-1:0] eff_addr;
    logic [DW-1:0]     arr_rd;
    logic              live;

    // R1, R2, R3, R4, R5, R7: cycle decode with host strobe first
    always_comb begin
        sel_ok    = !sel_a_n && sel_b && !sel_c_n;
        wr_term   = !wr_all_n || !wr_byte_n;
        lane_mask = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_n : '0);
        if (!sel_a_n && !host_strb_n) begin
            kind   = sel_ok ? CY_LOAD : CY_IDLE;
            cyc_wr = 1'b0;
        end else if (!ctl_strb_n) begin
            kind   = sel_ok ? CY_LOAD : CY_IDLE;
            cyc_wr = wr_term;
        end else begin
            kind   = step_n ? CY_HOLD : CY_STEP;
            cyc_wr = wr_term;
        end
    end

    sbs_burst_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (kind == CY_LOAD),
        .adv     (kind == CY_STEP),
        .load_lo (addr[1:0]),
        .linear  (seq_linear),
        .eff_lo  (eff_lo)
    );

    always_comb begin
        st_d     = st_q;
        st_d.hi  = (kind == CY_LOAD) ? addr[ADDR_W-1:2] : st_q.hi;
        eff_addr = {st_d.hi, eff_lo};
        we       = (kind != CY_IDLE && cyc_wr) ? lane_mask : '0;
        st_d.rdv = (kind != CY_IDLE) && !cyc_wr;
        if (st_d.rdv) st_d.raddr = eff_addr;
        st_d.pv    = st_q.rdv;
        st_d.pdata = arr_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sbs_array #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .ADDR_W (ADDR_W)
    ) u_arr (
        .clk   (clk),
        .we    (we),
        .waddr (eff_addr),
        .wdata (din),
        .raddr (st_q.raddr),
        .rdata (arr_rd)
    );

    // R8, R10, R12: output selection by latency mode
    assign live   = pipe_mode ? st_q.pv : st_q.rdv;
    assign dout   = live ? (pipe_mode ? st_q.pdata : arr_rd) : '0;
    assign drv_en = live && !out_en_n;

    // R2: idle cycle in flow-through mode leaves drivers off after the edge
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_IDLE && !pipe_mode) |=> !drv_en);

    // R11: in pipelined mode drivers turn off one cycle after the last read data
    a_r11_scd_off: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_IDLE && pipe_mode) |=> ##1 !drv_en);

    // R9: a flow-through write cycle never drives the pins
    a_r9_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CY_IDLE && cyc_wr && !pipe_mode) |=> !drv_en);

endmodule

// File: tb/sim_sbsram_core.sv
module sim_sbsram_core;

    localparam int PER = 10;
    localparam int LANES = 4, LANE_W = 9, ADDR_W = 6;
    localparam int DW = LANES * LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic host_strb_n = 1'b1, ctl_strb_n = 1'b0, step_n = 1'b1;
    logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [LANES-1:0] lane_n = '1;
    logic seq_linear = 1'b1, pipe_mode = 1'b0, out_en_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic drv_en;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    logic [DW-1:0] mm [DEPTH];
    int m_hi = 0, m_base = 0, m_cnt = 0, m_raddr = 0;
    bit m_fv = 0, m_pv = 0;
    logic [DW-1:0] m_fd = '0, m_pd = '0;

    always #(PER/2) clk = ~clk;

    sbsram_core #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .host_strb_n(host_strb_n), .ctl_strb_n(ctl_strb_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .seq_linear(seq_linear), .pipe_mode(pipe_mode), .out_en_n(out_en_n),
        .din(din), .dout(dout), .drv_en(drv_en)
    );

    function automatic logic [DW-1:0] pat(input int a);
        logic [DW-1:0] v;
        v = DW'(a) * 36'h0_1357_9BDF;
        return v ^ 36'hA_5C3C_9669;
    endfunction

    task automatic model_reset();
        m_hi = 0; m_base = 0; m_cnt = 0; m_raddr = 0;
        m_fv = 0; m_pv = 0; m_fd = '0; m_pd = '0;
    endtask

    task automatic model_edge();
        bit sel_ok, wt, w;
        int kind; // 0 idle, 1 load, 2 step, 3 hold
        int ea;
        logic [DW-1:0] bm;
        sel_ok = !sel_a_n && sel_b && !sel_c_n;
        wt = !wr_all_n || !wr_byte_n;
        if (!sel_a_n && !host_strb_n) begin kind = sel_ok ? 1 : 0; w = 0; end
        else if (!ctl_strb_n)         begin kind = sel_ok ? 1 : 0; w = wt; end
        else                          begin kind = step_n ? 3 : 2; w = wt; end
        m_pv = m_fv; m_pd = m_fd;
        if (kind == 1) begin m_hi = int'(addr) / 4; m_base = int'(addr) % 4; m_cnt = 0; end
        else if (kind == 2) m_cnt = (m_cnt + 1) % 4;
        ea = m_hi * 4 + (seq_linear ? (m_base + m_cnt) % 4 : (m_base ^ m_cnt));
        m_fv = 0;
        if (kind != 0) begin
            if (w) begin
                bm = '0;
                for (int i = 0; i < LANES; i++)
                    if (!wr_all_n || !lane_n[i]) bm[i*LANE_W +: LANE_W] = '1;
                mm[ea] = (mm[ea] & ~bm) | (din & bm);
            end else begin
                m_fv = 1; m_raddr = ea;
            end
        end
        m_fd = mm[m_raddr];
    endtask

    task automatic check(input string tag);
        bit live;
        logic [DW-1:0] ed;
        bit edrv;
        live = pipe_mode ? m_pv : m_fv;
        ed   = live ? (pipe_mode ? m_pd : m_fd) : '0;
        edrv = live && !out_en_n;
        n_chk++;
        if (dout !== ed || drv_en !== edrv) begin
            n_fail++;
            $display("FAIL %s: dout=%h drv_en=%b expected dout=%h drv_en=%b",
                     tag, dout, drv_en, ed, edrv);
        end
    endtask

    // called just after a falling edge with inputs already set
    task automatic tick(input string tag);
        @(posedge clk);
        if (rst_n) model_edge(); else model_reset();
        #(PER/4);
        check(tag);
        @(negedge clk);
    endtask

    task automatic clr_wr();
        wr_all_n = 1; wr_byte_n = 1; lane_n = '1;
    endtask

    task automatic desel();
        sel_a_n = 1; sel_b = 1; sel_c_n = 0; host_strb_n = 1; ctl_strb_n = 0; step_n = 1; clr_wr();
    endtask

    task automatic rd_ctl(input int a);
        sel_a_n = 0; sel_b = 1; sel_c_n = 0; host_strb_n = 1; ctl_strb_n = 0; step_n = 1;
        addr = ADDR_W'(a); clr_wr();
    endtask

    task automatic rd_host(input int a);
        sel_a_n = 0; sel_b = 1; sel_c_n = 0; host_strb_n = 0; ctl_strb_n = 1; step_n = 1;
        addr = ADDR_W'(a); clr_wr();
    endtask

    task automatic wr_ctl(input int a, input logic [DW-1:0] d, input bit all, input logic [LANES-1:0] ln);
        sel_a_n = 0; sel_b = 1; sel_c_n = 0; host_strb_n = 1; ctl_strb_n = 0; step_n = 1;
        addr = ADDR_W'(a); din = d;
        wr_all_n = !all; wr_byte_n = all; lane_n = ln;
    endtask

    task automatic cont(input bit stp);
        host_strb_n = 1; ctl_strb_n = 1; step_n = !stp; clr_wr();
    endtask

    initial begin
        #(PER * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        @(negedge clk);
        desel();
        tick("R12"); tick("R12"); tick("R12");
        rst_n = 1;
        tick("R12");

        // fill the array with full-word writes, flow-through mode
        for (int a = 0; a < DEPTH; a++) begin
            wr_ctl(a, pat(a), 1, '1);
            tick("R4 R9");
        end
        desel(); tick("R2");

        // R3: host strobe read ignores asserted write controls
        rd_host(5); wr_all_n = 0; din = '0;
        tick("R3 R8");
        // R5 R6: linear steps from low bits 01, wrap after fourth beat
        cont(1); tick("R5 R6"); cont(1); tick("R5 R6"); cont(1); tick("R6");
        cont(1); tick("R6 wrap");
        cont(0); tick("R5 hold");
        cont(0); wr_all_n = 1; tick("R5 hold");
        desel(); tick("R2");

        // R6: interleaved order from low bits 10
        seq_linear = 0;
        rd_ctl(22); tick("R4 read");
        for (int k = 0; k < 4; k++) begin cont(1); tick("R6 interleave"); end
        desel(); tick("R2"); seq_linear = 1;

        // R1: partial selection makes strobe starts idle
        wr_ctl(9, '0, 1, '1); sel_b = 0; tick("R1");
        wr_ctl(9, '0, 1, '1); sel_c_n = 1; tick("R1");
        rd_host(9); sel_c_n = 1; tick("R1");
        rd_ctl(9); tick("R1 R13 data kept");
        // R2: host strobe ignored when primary select is high -> step
        sel_a_n = 1; host_strb_n = 0; ctl_strb_n = 1; step_n = 0; tick("R2 host ignored");
        desel(); tick("R2");

        // R7: lane-masked write, empty mask, and read when both write inputs high
        wr_ctl(12, '1, 0, 4'b1010); tick("R7 lanes");
        wr_ctl(13, '1, 0, 4'b1111); tick("R7 empty mask");
        wr_ctl(14, '1, 0, 4'b0000); wr_byte_n = 1; tick("R7 read");
        rd_ctl(12); tick("R7 R9 readback");
        rd_ctl(13); tick("R7 readback");
        // R9: write directly after read turns drivers off
        wr_ctl(15, pat(99), 0, 4'b0110); tick("R9");
        rd_ctl(15); tick("R13");

        // R5 R13: burst write with step, then read back
        wr_ctl(33, pat(7), 1, '1); tick("R5 burst write");
        host_strb_n = 1; ctl_strb_n = 1; step_n = 0; din = pat(8); tick("R5 step write");
        step_n = 1; din = pat(9); tick("R5 hold write");
        desel(); tick("R2");
        rd_ctl(33); tick("R13"); cont(1); tick("R13"); cont(1); tick("R13");

        // R10: asynchronous output enable
        rd_ctl(40); tick("R10");
        out_en_n = 1; #1; check("R10 async off");
        out_en_n = 0; #1; check("R10 async on");
        cont(1); out_en_n = 1; tick("R10 held off");
        out_en_n = 0;
        desel(); tick("R2"); tick("R2");

        // R8 R11: pipelined mode
        pipe_mode = 1;
        tick("R8 idle");
        rd_ctl(44); tick("R8 first edge");
        cont(1); tick("R8 data");
        cont(1); tick("R8 beat");
        desel(); tick("R11 last data");
        tick("R11 off");
        rd_ctl(50); tick("R8");
        wr_ctl(50, pat(3), 1, '1); tick("R8 R9");
        rd_ctl(50); tick("R9 write slot");
        tick("R13 pipe");
        cont(0); out_en_n = 1; tick("R10 pipe");
        out_en_n = 0;
        desel(); tick("R11"); tick("R11"); tick("R11");
        pipe_mode = 0;

        // R12: reset mid-run clears outputs
        rd_ctl(3); tick("R8");
        rst_n = 0; tick("R12");
        rst_n = 1; desel(); tick("R12");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule